// File: doc/BRIEF.md
# Timestamped Histogram Packet Packager

This block takes the per-bin histogram words produced by two synchronized receive channels and sends them to the host as a single output stream. The stream is cut into fixed-length packets. Each frame carries a full block of channel-0 words followed by a full block of channel-1 words. A group of frames forms a burst: one host read. The number of frames in a burst comes from a control input. The output uses a valid/ready handshake with a packet-end flag and a burst-end flag.

When a burst begins, the block takes a 64-bit hardware time value from channel 0. It does so only if channel 0 flags that its time value is valid. The captured time is presented as two 32-bit read words. The captured value stays frozen for the rest of the burst, so software reading the two halves at any point of the burst gets a coherent pair. Channel 1 carries no time value, because both channels share a common sample clock.

Top module: `ts_packet_packager`

## Requirements
- R1: `out_last` is high on every 256th sample sent within a burst, counting from the burst's first sample. It is low on all other samples.
- R2: Each frame is 512 samples taken from `in0` in arrival order, then 512 samples taken from `in1` in arrival order. Only the channel currently selected may see its ready input high.
- R3: `frame_count` is sampled when the first sample of a burst is accepted, and a burst then holds that many frames. A value of 0 is treated as 1.
- R4: `out_eob` is high, together with `out_last`, on the final sample of a burst and on no other sample.
- R5: On the first accepted sample of a burst, the time value `in0_time` is captured if `in0_time_ok` is high. If `in0_time_ok` is low, the previously captured value is kept.
- R6: `time_lo` shows bits 31:0 of the captured time and `time_hi` shows bits 63:32.
- R7: The captured time does not change while a burst is in progress.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_eob` hold their values on the next cycle.
- R9: After reset, `out_valid`, `out_last`, `out_eob`, `time_lo` and `time_hi` are zero, and the first accepted sample starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_data | input | 8 | Channel 0 histogram word |
| in0_valid | input | 1 | Channel 0 word present |
| in0_ready | output | 1 | Channel 0 word taken this cycle |
| in0_time_ok | input | 1 | Channel 0 time value is meaningful |
| in0_time | input | 64 | Channel 0 hardware time value |
| in1_data | input | 8 | Channel 1 histogram word |
| in1_valid | input | 1 | Channel 1 word present |
| in1_ready | output | 1 | Channel 1 word taken this cycle |
| frame_count | input | 8 | Frames per burst (0 acts as 1) |
| out_data | output | 8 | Output sample |
| out_valid | output | 1 | Output sample present |
| out_last | output | 1 | Final sample of a packet |
| out_eob | output | 1 | Final sample of a burst |
| out_ready | input | 1 | Downstream accepts the sample |
| time_lo | output | 32 | Captured time, low word |
| time_hi | output | 32 | Captured time, high word |

## Verification
A wrong position count appears at the ports at the next packet edge at the latest. It shows either as `out_last` landing on the wrong sample, or as the channel tag in the data switching at a point other than the middle of a frame. A wrong frame or target count may stay hidden until the end of a burst, when `out_eob` comes early, comes late, or never comes. A capture fault in the time register appears one cycle after the first sample of a burst, or on any cycle inside the burst if a stray write occurs.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    typedef enum logic {
        SRC_CH0 = 1'b0,
        SRC_CH1 = 1'b1
    } src_e;

endpackage

// File: rtl/pkt_burst_tracker.sv
module pkt_burst_tracker
    import pkt_pkg::*;
#(
    parameter int PKT_LEN      = 256,
    parameter int STREAM_WORDS = 512,
    parameter int FN_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [FN_W-1:0] frame_num,
    output src_e            src,
    output logic            first,
    output logic            pkt_end,
    output logic            burst_end,
    output logic            active
);

    localparam int FRAME_LEN = 2 * STREAM_WORDS;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef struct packed {
        logic            active;
        logic [FN_W-1:0] target;
        logic [FN_W-1:0] frame;
        logic [IDX_W-1:0] idx;
    } trk_t;

    trk_t s_q, s_d;

    logic [FN_W-1:0] tgt_eff;
    logic [FN_W-1:0] frame_eff;
    logic            frame_end;

    always_comb begin
        tgt_eff   = s_q.active ? s_q.target
                  : ((frame_num == '0) ? FN_W'(1) : frame_num);
        frame_eff = s_q.active ? s_q.frame : '0;
        frame_end = (s_q.idx == IDX_W'(FRAME_LEN - 1));
        pkt_end   = ((s_q.idx & IDX_W'(PKT_LEN - 1)) == IDX_W'(PKT_LEN - 1));
        burst_end = frame_end && (frame_eff == (tgt_eff - FN_W'(1)));

        s_d = s_q;
        if (accept) begin
            s_d.active = !burst_end;
            s_d.target = tgt_eff;
            s_d.idx    = frame_end ? '0 : (s_q.idx + IDX_W'(1));
            if (burst_end) begin
                s_d.frame = '0;
            end else if (frame_end) begin
                s_d.frame = frame_eff + FN_W'(1);
            end else begin
                s_d.frame = frame_eff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign src    = (s_q.idx < IDX_W'(STREAM_WORDS)) ? SRC_CH0 : SRC_CH1;
    assign first  = !s_q.active;
    assign active = s_q.active;

    AST_IDLE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> (s_q.idx == '0)); // R9
    AST_FRAME_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.frame < s_q.target)); // R3
    AST_BURST_CLOSES_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && burst_end) |=> !s_q.active); // R3

endmodule

// File: rtl/pkt_ts_capture.sv
module pkt_ts_capture #(
    parameter int TS_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TS_W-1:0]   ts_in,
    output logic [TS_W/2-1:0] ts_lo,
    output logic [TS_W/2-1:0] ts_hi
);

    localparam int HALF_W = TS_W / 2;

    typedef struct packed {
        logic [TS_W-1:0] stamp;
    } ts_t;

    ts_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (capture) begin
            s_d.stamp = ts_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ts_lo = s_q.stamp[HALF_W-1:0];
    assign ts_hi = s_q.stamp[TS_W-1:HALF_W];

    AST_CAPTURE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ({ts_hi, ts_lo} == $past(ts_in))); // R5

endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              last_in,
    input  logic              eob_in,
    input  logic              out_ready,
    output logic              can_load,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic              out_eob
);

    typedef struct packed {
        logic              valid;
        logic              last;
        logic              eob;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t s_q, s_d;

    always_comb begin
        can_load = !s_q.valid || out_ready;
        s_d      = s_q;
        if (load) begin
            s_d = '{valid: 1'b1, last: last_in, eob: eob_in, data: data_in};
        end else if (out_ready) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_last  = s_q.valid && s_q.last;
    assign out_eob   = s_q.valid && s_q.eob;
    assign out_data  = s_q.data;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_eob))); // R8
    AST_NO_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !load); // R8

endmodule

// File: rtl/ts_packet_packager.sv
module ts_packet_packager
    import pkt_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TS_W         = 64,
    parameter int PKT_LEN      = 256,
    parameter int STREAM_WORDS = 512,
    parameter int FN_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in0_data,
    input  logic              in0_valid,
    output logic              in0_ready,
    input  logic              in0_time_ok,
    input  logic [TS_W-1:0]   in0_time,
    input  logic [DATA_W-1:0] in1_data,
    input  logic              in1_valid,
    output logic              in1_ready,
    input  logic [FN_W-1:0]   frame_count,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic              out_eob,
    input  logic              out_ready,
    output logic [TS_W/2-1:0] time_lo,
    output logic [TS_W/2-1:0] time_hi
);

    src_e              src;
    logic              first;
    logic              pkt_end;
    logic              burst_end;
    logic              active;
    logic              can_load;
    logic              sel_valid;
    logic [DATA_W-1:0] sel_data;
    logic              accept;
    logic              capture;

    always_comb begin
        sel_valid = (src == SRC_CH0) ? in0_valid : in1_valid;
        sel_data  = (src == SRC_CH0) ? in0_data  : in1_data;
        accept    = sel_valid && can_load;
        in0_ready = can_load && (src == SRC_CH0);
        in1_ready = can_load && (src == SRC_CH1);
        capture   = accept && first && in0_time_ok;
    end

    pkt_burst_tracker #(
        .PKT_LEN      (PKT_LEN),
        .STREAM_WORDS (STREAM_WORDS),
        .FN_W         (FN_W)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .frame_num (frame_count),
        .src       (src),
        .first     (first),
        .pkt_end   (pkt_end),
        .burst_end (burst_end),
        .active    (active)
    );

    pkt_out_stage #(
        .DATA_W (DATA_W)
    ) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .data_in   (sel_data),
        .last_in   (pkt_end),
        .eob_in    (burst_end),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_eob   (out_eob)
    );

    pkt_ts_capture #(
        .TS_W (TS_W)
    ) i_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .ts_in   (in0_time),
        .ts_lo   (time_lo),
        .ts_hi   (time_hi)
    );

    AST_SINGLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(in0_ready && in1_ready)); // R2
    AST_TS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(time_lo) && $stable(time_hi))); // R7
    AST_EOB_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eob) |-> out_last); // R4

endmodule

// File: tb/test_ts_packet_packager.sv
`timescale 1ns/1ps
module test_ts_packet_packager;

    localparam int FRAME_LEN = 1024;
    localparam int HALF      = 512;
    localparam int PKT       = 256;

    typedef struct packed {
        logic [7:0] frames;
        logic [7:0] exp_frames;
        logic       in_stall;
        logic       out_stall;
        logic       time_ok;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd2, 8'd2, 1'b1, 1'b0, 1'b1},
        '{8'd8, 8'd8, 1'b0, 1'b0, 1'b1},
        '{8'd0, 8'd1, 1'b0, 1'b1, 1'b0},
        '{8'd3, 8'd3, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in0_data = '0, in1_data = '0;
    logic        in0_valid = 1'b0, in1_valid = 1'b0;
    logic        in0_ready, in1_ready;
    logic        in0_time_ok = 1'b0;
    logic [63:0] in0_time = '0;
    logic [7:0]  frame_count = '0;
    logic [7:0]  out_data;
    logic        out_valid, out_last, out_eob;
    logic        out_ready = 1'b0;
    logic [31:0] time_lo, time_hi;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] cyc = '0;
    int cnt0 = 0, cnt1 = 0, e0 = 0, e1 = 0;
    logic [63:0] exp_ts = '0;

    always #5 clk = ~clk;

    ts_packet_packager i_ts_packet_packager (
        .clk(clk), .rst_n(rst_n),
        .in0_data(in0_data), .in0_valid(in0_valid), .in0_ready(in0_ready),
        .in0_time_ok(in0_time_ok), .in0_time(in0_time),
        .in1_data(in1_data), .in1_valid(in1_valid), .in1_ready(in1_ready),
        .frame_count(frame_count),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_eob(out_eob), .out_ready(out_ready),
        .time_lo(time_lo), .time_hi(time_hi)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_burst(input vec_t v, input logic [31:0] tag);
        int total, per_ch, sent0, sent1, n;
        logic done, started, armed, ts_bad, hold_prev, f0, f1;
        logic [9:0] held;
        total = int'(v.exp_frames) * FRAME_LEN;
        per_ch = total / 2;
        sent0 = 0; sent1 = 0; n = 0;
        done = 1'b0; started = 1'b0; armed = 1'b0; ts_bad = 1'b0; hold_prev = 1'b0;
        held = '0;
        frame_count = v.frames;
        in0_time_ok = v.time_ok;
        while (!done) begin
            @(negedge clk);
            if (started) armed = 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in0_valid = (sent0 < per_ch) && (v.in_stall ? lfsr[0] : 1'b1);
            in1_valid = (sent1 < per_ch) && (v.in_stall ? lfsr[3] : 1'b1);
            out_ready = v.out_stall ? lfsr[6] : 1'b1;
            in0_data = {1'b0, 7'(cnt0)};
            in1_data = {1'b1, 7'(cnt1)};
            in0_time = {tag, cyc};
            cyc++;
            #1;
            f0 = in0_valid && in0_ready;
            f1 = in1_valid && in1_ready;
            if (armed && ({time_hi, time_lo} != exp_ts)) ts_bad = 1'b1;
            if (f0) begin
                if (!started && v.time_ok) exp_ts = in0_time;
                started = 1'b1;
                cnt0++; sent0++;
            end
            if (f1) begin cnt1++; sent1++; end
            if (hold_prev)
                chk(out_valid && ({out_data, out_last, out_eob} == held), "R8",
                    "output held under backpressure",
                    {53'd0, out_valid, out_data, out_last, out_eob},
                    {53'd0, 1'b1, held});
            hold_prev = out_valid && !out_ready;
            held = {out_data, out_last, out_eob};
            if (out_valid && out_ready) begin
                logic [7:0] ed;
                if ((n % FRAME_LEN) < HALF) begin ed = {1'b0, 7'(e0)}; e0++; end
                else begin ed = {1'b1, 7'(e1)}; e1++; end
                chk(out_data == ed, "R2", "sample data and channel order",
                    {56'd0, out_data}, {56'd0, ed});
                chk(out_last == ((n % PKT) == PKT - 1), "R1", "packet end flag",
                    {63'd0, out_last}, {63'd0, ((n % PKT) == PKT - 1)});
                chk(out_eob == (n == total - 1), "R4", "burst end flag",
                    {63'd0, out_eob}, {63'd0, (n == total - 1)});
                n++;
                if (out_eob || n >= total) done = 1'b1;
            end
        end
        chk(n == total, "R3", "samples per burst", 64'(n), 64'(total));
        @(negedge clk);
        in0_valid = 1'b0; in1_valid = 1'b0;
        chk(!ts_bad, "R7", "time words frozen during burst", {63'd0, ts_bad}, 64'd0);
        chk(time_lo == exp_ts[31:0], "R5", "captured time low word (R6)",
            {32'd0, time_lo}, {32'd0, exp_ts[31:0]});
        chk(time_hi == exp_ts[63:32], "R6", "captured time high word",
            {32'd0, time_hi}, {32'd0, exp_ts[63:32]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && !out_eob, "R9", "outputs idle in reset",
            {61'd0, out_valid, out_last, out_eob}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({time_hi, time_lo} == 64'd0, "R9", "time words cleared by reset",
            {time_hi, time_lo}, 64'd0);
        chk(!out_valid, "R9", "no output without input", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < 4; i++) begin
            run_burst(VECS[i], 32'hC0DE_0000 + 32'(i));
        end

        // Reset between bursts clears captured time; next burst without time flag keeps zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && ({time_hi, time_lo} == 64'd0), "R9", "reset after bursts",
            {time_hi, time_lo}, 64'd0);
        rst_n = 1'b1;
        exp_ts = '0;
        run_burst('{8'd1, 8'd1, 1'b0, 1'b0, 1'b0}, 32'hBEEF_0001);
        run_burst('{8'd1, 8'd1, 1'b1, 1'b1, 1'b1}, 32'hBEEF_0002);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule